// File: doc/BRIEF.md
# Write Protection Command Sequence Detector

This block sits beside the write path of a byte-wide, 15-bit-addressed non-volatile memory. It watches every byte write the memory accepts and looks for two fixed unlock-style command sequences built from address/data pairs. One sequence turns software write protection on, the other turns it off. The block holds the resulting protect flag, which the memory core uses to block ordinary stray writes while protection is active.

A write counts only when the write strobe is high and the memory is not busy. The enable sequence is three accepted writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h. The disable sequence is six accepted writes: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, 20h to 5555h. The first two steps are shared, and the third byte picks the branch. Any accepted write that is not the expected next pair sends the matcher back to idle. If that write is AAh to 5555h, it counts as a new first step. Every accepted write that the matcher takes as a step is marked in the same cycle, so the memory core can drop it.

Top module: `wrprot_seq`

## Requirements
- R1: After reset, prot_on is 0 and the matcher is idle. The enable sequence as the very first writes sets protection.
- R2: The three accepted writes AAh@5555h, 55h@2AAAh, A0h@5555h, in order, make prot_on 1 from the clock edge that accepts the third write.
- R3: The six accepted writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h, in order, make prot_on 0 from the clock edge that accepts the sixth write.
- R4: A write offered with busy=1 is ignored. It does not advance or reset the matcher, does not change prot_on, and keeps cmd_swallow at 0.
- R5: An accepted write that is not the expected next pair returns the matcher to idle, so the remaining steps of the sequence no longer complete it.
- R6: A mismatching accepted write that is itself AAh@5555h is taken as the first step of a new sequence.
- R7: cmd_swallow is 1, combinationally in the cycle of the write, exactly when the write is accepted and is taken as a sequence step (expected next pair, or a restart with AAh@5555h). Otherwise it is 0.
- R8: prot_on changes only on completion of a full sequence. Enabling while already on leaves it at 1, and disabling while off leaves it at 0.
- R9: Cycles with wr_vld=0 between steps do not break a sequence, because steps are counted over accepted writes only.
- R10: After the shared first two steps, A0h@5555h finishes the enable sequence and 80h@5555h enters the disable branch. Inside the disable branch, A0h@5555h is a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_vld | input | 1 | Byte-write strobe, one cycle per write |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Memory internal write cycle in progress; writes are ignored |
| prot_on | output | 1 | Software write protection active |
| cmd_swallow | output | 1 | Current accepted write is a command step |

## Verification
The hardest situation to reach from the ports is a sequence broken partway by a write that is itself a valid first step, especially deep in the disable branch, where AAh@5555h is both the expected pair at one step and a restart at the next. Random stimulus favours the six command pairs over arbitrary writes, so long partial sequences occur often. It also mixes in busy cycles and idle gaps, so frozen-matcher cases land at every depth. Directed cases add restart chains, branch selection, and repeated enables and disables.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;

  // matcher position within a command sequence
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,  // first unlock pair seen
    ST_K2   = 3'd2,  // second unlock pair seen
    ST_P3   = 3'd3,  // disable branch selected
    ST_P4   = 3'd4,  // disable branch, repeat of first pair seen
    ST_P5   = 3'd5   // disable branch, repeat of second pair seen
  } seq_state_t;

  // index of each recognised address/data pair in the hit vector
  localparam int NUM_PAIR = 5;
  localparam int IX_KEY1  = 0;
  localparam int IX_KEY2  = 1;
  localparam int IX_ON    = 2;
  localparam int IX_PRE   = 3;
  localparam int IX_OFF   = 4;

endpackage

// File: rtl/wrprot_rst_sync.sv
module wrprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= {sr_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/wrprot_classify.sv
module wrprot_classify
  import wrprot_pkg::*;
#(
  parameter int              ADDR_W  = 15,
  parameter int              DATA_W  = 8,
  parameter logic [ADDR_W-1:0] ADDR_A  = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B  = 15'h2AAA,
  parameter logic [DATA_W-1:0] D_KEY1  = 8'hAA,
  parameter logic [DATA_W-1:0] D_KEY2  = 8'h55,
  parameter logic [DATA_W-1:0] D_ON    = 8'hA0,
  parameter logic [DATA_W-1:0] D_PRE   = 8'h80,
  parameter logic [DATA_W-1:0] D_OFF   = 8'h20
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   data,
  output logic [NUM_PAIR-1:0] hit
);

  localparam logic [ADDR_W-1:0] PAIR_A [NUM_PAIR] =
    '{ADDR_A, ADDR_B, ADDR_A, ADDR_A, ADDR_A};
  localparam logic [DATA_W-1:0] PAIR_D [NUM_PAIR] =
    '{D_KEY1, D_KEY2, D_ON, D_PRE, D_OFF};

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    assign hit[k] = (addr == PAIR_A[k]) && (data == PAIR_D[k]);
  end

endmodule

// File: rtl/wrprot_fsm.sv
module wrprot_fsm
  import wrprot_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic [NUM_PAIR-1:0] hit,
  output logic                step_ok,
  output logic                set_p,
  output logic                clr_p
);

  seq_state_t st_q, st_d;
  seq_state_t restart;

  always_comb begin
    restart = hit[IX_KEY1] ? ST_K1 : ST_IDLE;
    st_d    = st_q;
    step_ok = 1'b0;
    set_p   = 1'b0;
    clr_p   = 1'b0;
    if (acc) begin
      st_d    = restart;
      step_ok = hit[IX_KEY1];
      case (st_q)
        ST_K1: begin
          if (hit[IX_KEY2]) begin
            st_d    = ST_K2;
            step_ok = 1'b1;
          end
        end
        ST_K2: begin
          if (hit[IX_ON]) begin
            st_d    = ST_IDLE;
            step_ok = 1'b1;
            set_p   = 1'b1;
          end else if (hit[IX_PRE]) begin
            st_d    = ST_P3;
            step_ok = 1'b1;
          end
        end
        ST_P3: begin
          if (hit[IX_KEY1]) begin
            st_d = ST_P4;
          end
        end
        ST_P4: begin
          if (hit[IX_KEY2]) begin
            st_d    = ST_P5;
            step_ok = 1'b1;
          end
        end
        ST_P5: begin
          if (hit[IX_OFF]) begin
            st_d    = ST_IDLE;
            step_ok = 1'b1;
            clr_p   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (acc) begin
      st_q <= st_d;
    end
  end

  // R4: with no accepted write the matcher position holds
  a_r4_hold_when_not_acc: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(st_q));

  // R7: a step is only flagged for an accepted write
  a_r7_step_needs_acc: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok |-> acc);

  // R10: enable completes only from the shared second step
  a_r10_set_from_k2: assert property (@(posedge clk) disable iff (!rst_n)
    set_p |-> (st_q == ST_K2));

  // R3: disable completes only from the last branch step
  a_r3_clr_from_p5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |-> (st_q == ST_P5));

  // R5: a non-step accepted write leaves the matcher idle
  a_r5_miss_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !step_ok) |=> (st_q == ST_IDLE));

  // only one completion at a time
  a_r8_set_clr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_p, clr_p}) <= 1);

endmodule

// File: rtl/wrprot_flag.sv
module wrprot_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic clr_p,
  output logic prot
);

  logic prot_q;
  logic upd_en;

  assign upd_en = set_p | clr_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
    end else if (upd_en) begin
      prot_q <= set_p;
    end
  end

  assign prot = prot_q;

  // R8: the flag moves only after a completed sequence
  a_r8_change_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $past(upd_en));

endmodule

// File: rtl/wrprot_seq.sv
module wrprot_seq
  import wrprot_pkg::*;
#(
  parameter int                ADDR_W = 15,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] D_KEY1 = 8'hAA,
  parameter logic [DATA_W-1:0] D_KEY2 = 8'h55,
  parameter logic [DATA_W-1:0] D_ON   = 8'hA0,
  parameter logic [DATA_W-1:0] D_PRE  = 8'h80,
  parameter logic [DATA_W-1:0] D_OFF  = 8'h20,
  parameter int                RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prot_on,
  output logic              cmd_swallow
);

  logic                rst_sync_n;
  logic                acc;
  logic [NUM_PAIR-1:0] hit;
  logic                step_ok;
  logic                set_p;
  logic                clr_p;

  wrprot_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign acc = wr_vld & ~busy & rst_sync_n;

  wrprot_classify #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .ADDR_A (ADDR_A), .ADDR_B (ADDR_B),
    .D_KEY1 (D_KEY1), .D_KEY2 (D_KEY2),
    .D_ON   (D_ON),   .D_PRE  (D_PRE), .D_OFF (D_OFF)
  ) u_cls (
    .addr (wr_addr),
    .data (wr_data),
    .hit  (hit)
  );

  wrprot_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acc     (acc),
    .hit     (hit),
    .step_ok (step_ok),
    .set_p   (set_p),
    .clr_p   (clr_p)
  );

  wrprot_flag u_flag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_p (set_p),
    .clr_p (clr_p),
    .prot  (prot_on)
  );

  assign cmd_swallow = step_ok;

  // R4: a busy memory never has a write swallowed
  a_r4_busy_no_swallow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> !cmd_swallow);

  // R4: protection is untouched by a write offered while busy
  a_r4_busy_keeps_prot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> $stable(prot_on));

  // R2: enable completion is visible on the next cycle
  a_r2_set_visible: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_p |=> prot_on);

  // R3: disable completion is visible on the next cycle
  a_r3_clr_visible: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_p |=> !prot_on);

  // R6: the first unlock pair, when accepted, is always swallowed
  a_r6_key1_swallowed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc && hit[IX_KEY1]) |-> cmd_swallow);

endmodule

// File: tb/test_wrprot_seq.sv
module test_wrprot_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_vld;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy;
  logic        prot_on;
  logic        cmd_swallow;

  int n_chk  = 0;
  int n_fail = 0;
  int mst    = 0;   // model: 0 idle,1 k1,2 k2,3 p3,4 p4,5 p5
  bit mprot  = 1'b0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wrprot_seq i_wrprot_seq (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .prot_on(prot_on), .cmd_swallow(cmd_swallow)
  );

  // 1 key1, 2 key2, 3 on, 4 pre, 5 off, 0 other
  function automatic int pclass(logic [14:0] a, logic [7:0] d);
    if (a == 15'h5555 && d == 8'hAA) return 1;
    if (a == 15'h2AAA && d == 8'h55) return 2;
    if (a == 15'h5555 && d == 8'hA0) return 3;
    if (a == 15'h5555 && d == 8'h80) return 4;
    if (a == 15'h5555 && d == 8'h20) return 5;
    return 0;
  endfunction

  // expected state index: the pair the model waits for in each state
  function automatic int want(int s);
    case (s)
      0: return 1;
      1: return 2;
      3: return 1;
      4: return 2;
      5: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic chk(bit got, bit exp, string tag, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  // one clock: drive, check swallow, clock, check protect
  task automatic cyc(bit v, logic [14:0] a, logic [7:0] d, bit b, string tag);
    bit acc;
    bit ok;
    int c;
    int ns;
    @(negedge clk);
    wr_vld = v; wr_addr = a; wr_data = d; busy = b;
    acc = v && !b;
    c   = pclass(a, d);
    ok  = 1'b0;
    ns  = mst;
    if (acc) begin
      ns = (c == 1) ? 1 : 0;
      ok = (c == 1);
      if (mst == 2) begin
        if (c == 3) begin ns = 0; ok = 1; mprot = 1'b1; end
        else if (c == 4) begin ns = 3; ok = 1; end
      end else if (c == want(mst)) begin
        ok = 1;
        case (mst)
          0: ns = 1;
          1: ns = 2;
          3: ns = 4;
          4: ns = 5;
          5: begin ns = 0; mprot = 1'b0; end
          default: ;
        endcase
      end
    end
    #1;
    chk(cmd_swallow, ok, tag, "cmd_swallow");
    mst = ns;
    @(posedge clk);
    #1;
    chk(prot_on, mprot, tag, "prot_on");
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d, string tag);
    cyc(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic seq_on(string tag);
    wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'hA0, tag);
  endtask

  task automatic seq_off(string tag);
    wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'h80, tag);
    wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'h20, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; wr_vld = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0;
    repeat (3) @(negedge clk);
    #1; chk(prot_on, 1'b0, "R1", "prot_on in reset");
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, '0, '0, 1'b0, "R1");

    // R1 / R2: first writes enable protection
    seq_on("R2");
    chk(prot_on, 1'b1, "R2", "prot_on after enable");
    // R8: enable again keeps it on, stray write does not clear
    seq_on("R8");
    wr(15'h1234, 8'h20, "R8");
    chk(prot_on, 1'b1, "R8", "prot_on held");
    // R3: disable
    seq_off("R3");
    chk(prot_on, 1'b0, "R3", "prot_on after disable");
    // R8: disable while off stays off
    seq_off("R8");
    chk(prot_on, 1'b0, "R8", "prot_on stays off");
    // R5: mismatch breaks enable
    wr(15'h5555, 8'hAA, "R5"); wr(15'h0001, 8'h00, "R5");
    wr(15'h2AAA, 8'h55, "R5"); wr(15'h5555, 8'hA0, "R5");
    chk(prot_on, 1'b0, "R5", "broken enable");
    // R6: repeated first pair restarts
    wr(15'h5555, 8'hAA, "R6"); seq_on("R6");
    chk(prot_on, 1'b1, "R6", "restart enable");
    // R6 deep in disable branch: AA at step five restarts
    wr(15'h5555, 8'hAA, "R6"); wr(15'h2AAA, 8'h55, "R6"); wr(15'h5555, 8'h80, "R6");
    wr(15'h5555, 8'hAA, "R6"); wr(15'h5555, 8'hAA, "R6");
    wr(15'h2AAA, 8'h55, "R6"); wr(15'h5555, 8'h20, "R6");
    chk(prot_on, 1'b1, "R6", "disable broken by restart");
    // R4: busy writes ignored mid-sequence
    wr(15'h5555, 8'hAA, "R4"); wr(15'h2AAA, 8'h55, "R4");
    cyc(1'b1, 15'h7FFF, 8'hFF, 1'b1, "R4");
    cyc(1'b1, 15'h5555, 8'h80, 1'b1, "R4");
    wr(15'h5555, 8'h80, "R4"); wr(15'h5555, 8'hAA, "R4");
    wr(15'h2AAA, 8'h55, "R4");
    cyc(1'b1, 15'h5555, 8'h20, 1'b1, "R4");
    chk(prot_on, 1'b1, "R4", "busy final step ignored");
    // R9: idle gap then final step
    cyc(1'b0, 15'h5555, 8'h20, 1'b0, "R9");
    cyc(1'b0, 15'h0000, 8'h00, 1'b0, "R9");
    wr(15'h5555, 8'h20, "R9");
    chk(prot_on, 1'b0, "R9", "gapped disable");
    // R10: A0 inside disable branch is a mismatch
    wr(15'h5555, 8'hAA, "R10"); wr(15'h2AAA, 8'h55, "R10"); wr(15'h5555, 8'h80, "R10");
    wr(15'h5555, 8'hA0, "R10");
    chk(prot_on, 1'b0, "R10", "A0 in branch");
    wr(15'h2AAA, 8'h55, "R10"); wr(15'h5555, 8'h20, "R10");
    chk(prot_on, 1'b0, "R10", "no stale branch");

    // R7: random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [14:0] a;
      logic [7:0]  d;
      sel = int'($urandom % 9);
      a = 15'($urandom); d = 8'($urandom);
      case (sel)
        0, 1: begin a = 15'h5555; d = 8'hAA; end
        2, 3: begin a = 15'h2AAA; d = 8'h55; end
        4: begin a = 15'h5555; d = 8'hA0; end
        5: begin a = 15'h5555; d = 8'h80; end
        6: begin a = 15'h5555; d = 8'h20; end
        7: begin a = 15'h2AAA; d = 8'hAA; end
        default: ;
      endcase
      cyc(($urandom % 7) != 0, a, d, ($urandom % 6) == 0, "R7");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule